// File: doc/BRIEF.md
# Dual-Channel Integrating Light Count Accumulator

This block is the digital back end of a two-channel integrating light converter. Each channel delivers a stream of single-cycle count pulses from a comparator. Over one integration window the block turns each stream into a count. The window length comes from a 2-bit timing selector, measured in oscillator cycles. At the end of the window both counts are loaded into their result registers together, and a one-cycle done strobe is raised. Both channels run at the same time over the same window. One channel is the broadband channel and the other is the infrared channel.

The fixed windows are whole multiples of a base unit of `UNIT` cycles. The default unit is 918 cycles. A channel accepts no more than one pulse in any two consecutive cycles. Two counts are lost as a fixed offset, and the result clamps at its all-ones ceiling. A gain select bit puts a divide-by-16 prescaler in front of both accumulators to give low gain. Selector value 3 is a manual mode: integration runs while the start input is held and finishes when it is released. Dropping the enable discards the window in progress.

Top module: `lux_integrator`

## Requirements
- R1: With `en` held, timing selector 0, 1 and 2 give windows of 11, 81 and 322 times `UNIT` cycles. `done` rises exactly one window length after the first enabled edge and then repeats every window length.
- R2: A channel accepts a pulse only if it did not accept one in the previous cycle. An input held high for a window of L cycles yields L/2 raw counts, and a pulse every 4th cycle yields L/4.
- R3: The reported result is the raw count minus 2, and it floors at 0. A channel with no pulses reports 0.
- R4: A result clamps at 2^RES_W-1 and never wraps.
- R5: With `gain_lo` = 1, a channel's raw count advances once per 16 accepted pulses, so the raw count is floor(accepted/16).
- R6: The two channels count independently and over the same window. Different input patterns give each channel its own result in the same strobe.
- R7: Both result outputs change only in the cycle in which `done` is high, and they keep their values otherwise.
- R8: `done` is high for exactly one cycle per completed window.
- R9: With selector 3, every cycle in which `man_go` is high is integrated. `done` and the results appear in the cycle after the first edge at which `man_go` is seen low. No further strobe comes while `man_go` stays low.
- R10: While `en` is low, no strobe is produced and the window in progress is discarded. A later window counts from zero.
- R11: After reset both results are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Conversion enable; low clears the window in progress |
| tsel | input | 2 | Window select: 0/1/2 fixed lengths, 3 manual |
| gain_lo | input | 1 | 1 selects low gain (divide-by-16 prescaler) |
| man_go | input | 1 | Manual-mode integrate input |
| pulse_a | input | 1 | Broadband channel count pulse |
| pulse_b | input | 1 | Infrared channel count pulse |
| res_a | output | RES_W (16) | Broadband channel result |
| res_b | output | RES_W (16) | Infrared channel result |
| done | output | 1 | One-cycle conversion-complete strobe |

## Verification
The assertions check the following on every cycle:
- the spacing of done strobes against the selected window length;
- that done is a single-cycle strobe;
- that the results change only together with done;
- that no strobe follows a cycle with the enable low;
- that a manual-mode strobe follows only the release of the start input.

The numeric results can only be shown by the bench's scenarios, which drive known pulse patterns through whole windows: the rate limit, the two-count offset, clamping, the low-gain division and channel independence. The bench also shows that an aborted window leaves no residue in the next one.

// File: rtl/lux_integrator.sv
module lux_integrator #(
  parameter int UNIT  = 918,
  parameter int M0    = 11,
  parameter int M1    = 81,
  parameter int M2    = 322,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       tsel,
  input  logic             gain_lo,
  input  logic             man_go,
  input  logic             pulse_a,
  input  logic             pulse_b,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             done
);
  localparam int LMAX = M2 * UNIT;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int AW   = RES_W + 1;
  localparam logic [AW-1:0] PEAK = AW'((1 << RES_W) - 1);
  localparam logic [AW-1:0] ACC_TOP = PEAK + AW'(2);

  logic [CW-1:0]    cnt, win;
  logic             go_q;
  logic [AW-1:0]    acc  [2];
  logic [3:0]       pre  [2];
  logic             took [2];
  logic [RES_W-1:0] res  [2];
  logic [1:0]       pin;

  assign pin    = {pulse_b, pulse_a};
  assign res_a  = res[0];
  assign res_b  = res[1];

  wire manual = (tsel == 2'b11);

  always_comb begin
    case (tsel)
      2'b00:   win = CW'(M0 * UNIT);
      2'b01:   win = CW'(M1 * UNIT);
      2'b10:   win = CW'(M2 * UNIT);
      default: win = '0;
    endcase
  end

  wire close  = manual ? (go_q && !man_go) : (cnt >= win - CW'(1));
  wire sample = manual ? man_go : !close;

  function automatic logic [RES_W-1:0] clip(input logic [AW-1:0] a);
    return (a < AW'(2)) ? '0 : RES_W'(a - AW'(2));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      go_q <= 1'b0;
      done <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        acc[c]  <= '0;
        pre[c]  <= '0;
        took[c] <= 1'b0;
        res[c]  <= '0;
      end
    end else if (!en) begin
      cnt  <= '0;
      go_q <= 1'b0;
      done <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        acc[c]  <= '0;
        pre[c]  <= '0;
        took[c] <= 1'b0;
      end
    end else begin
      go_q <= man_go;
      done <= close;
      if (close) begin
        cnt <= '0;
        for (int c = 0; c < 2; c++) begin
          res[c]  <= clip(acc[c]);
          acc[c]  <= '0;
          pre[c]  <= '0;
          took[c] <= 1'b0;
        end
      end else if (sample) begin
        if (!manual) cnt <= cnt + CW'(1);
        for (int c = 0; c < 2; c++) begin
          took[c] <= pin[c] && !took[c];
          if (pin[c] && !took[c]) begin
            if (gain_lo) pre[c] <= pre[c] + 4'd1;
            if ((!gain_lo || pre[c] == 4'hF) && acc[c] != ACC_TOP)
              acc[c] <= acc[c] + AW'(1);
          end
        end
      end else begin
        for (int c = 0; c < 2; c++) took[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lux_integrator_chk.sv
module lux_integrator_chk #(
  parameter int UNIT  = 918,
  parameter int M0    = 11,
  parameter int M1    = 81,
  parameter int M2    = 322,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       tsel,
  input logic             man_go,
  input logic [RES_W-1:0] res_a,
  input logic [RES_W-1:0] res_b,
  input logic             done
);
  localparam int GW = $clog2(M2 * UNIT + 2) + 1;

  logic [GW-1:0] gap;
  logic          valid;
  logic [1:0]    ts_q;
  logic [GW-1:0] wlen;

  always_comb begin
    case (tsel)
      2'b00:   wlen = GW'(M0 * UNIT);
      2'b01:   wlen = GW'(M1 * UNIT);
      default: wlen = GW'(M2 * UNIT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      valid <= 1'b0;
      ts_q  <= '0;
    end else begin
      ts_q <= tsel;
      if (!en) begin
        gap   <= '0;
        valid <= 1'b1;
      end else begin
        gap <= done ? GW'(1) : gap + GW'(1);
        if (tsel != ts_q) valid <= 1'b0;
        else if (done)    valid <= 1'b1;
      end
    end
  end

  assert_window_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && tsel != 2'b11 && $stable(tsel)) |-> gap == wlen);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_a != $past(res_a)) |-> done);

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_b != $past(res_b)) |-> done);

  assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);

  assert_manual_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tsel == 2'b11 && $past(tsel) == 2'b11) |-> (!$past(man_go) && $past(man_go, 2)));
endmodule

bind lux_integrator lux_integrator_chk #(
  .UNIT(UNIT), .M0(M0), .M1(M1), .M2(M2), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tsel(tsel), .man_go(man_go),
  .res_a(res_a), .res_b(res_b), .done(done)
);

// File: tb/sim_lux_integrator.sv
`timescale 1ns/1ps
module sim_lux_integrator;
  localparam int U  = 16;
  localparam int RW = 10;
  localparam int L0 = 11 * U, L1 = 81 * U, L2 = 322 * U;

  logic clk = 0, rst_n = 0, en = 0, gain_lo = 0, man_go = 0, pa = 0, pb = 0;
  logic [1:0] tsel = 2'b00;
  logic [RW-1:0] ra, rb;
  logic done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lux_integrator #(.UNIT(U), .RES_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tsel(tsel), .gain_lo(gain_lo),
    .man_go(man_go), .pulse_a(pa), .pulse_b(pb), .res_a(ra), .res_b(rb), .done(done)
  );

  function automatic logic pbit(int pat, int i);
    case (pat)
      1:       return 1'b1;
      2:       return (i % 4) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_cycles(int n, int p0, int p1, output int early);
    early = 0;
    for (int i = 0; i < n; i++) begin
      pa = pbit(p0, i);
      pb = pbit(p1, i);
      @(negedge clk);
      if (i < n - 1 && done) early++;
    end
  endtask

  task automatic window(logic [1:0] ts, logic g, int len, int p0, int p1,
                        int e0, int e1, string req);
    int early;
    en = 0; tsel = ts; gain_lo = g; man_go = 0;
    @(negedge clk);
    en = 1;
    run_cycles(len, p0, p1, early);
    chk("R1", "early strobe count", early, 0);
    chk("R1", "done at window end", int'(done), 1);
    chk(req, "res_a", int'(ra), e0);
    chk(req, "res_b", int'(rb), e1);
  endtask

  task automatic t_reset;
    chk("R11", "res_a after reset", int'(ra), 0);
    chk("R11", "res_b after reset", int'(rb), 0);
    chk("R11", "done after reset", int'(done), 0);
  endtask

  task automatic t_fullscale;
    window(2'b00, 1'b0, L0, 1, 0, L0/2 - 2, 0, "R2_R3");
  endtask

  task automatic t_period;
    int early;
    window(2'b00, 1'b0, L0, 2, 1, L0/4 - 2, L0/2 - 2, "R6");
    run_cycles(L0, 2, 1, early);
    chk("R1", "second window early strobes", early, 0);
    chk("R1", "second window done", int'(done), 1);
    chk("R6", "second window res_a", int'(ra), L0/4 - 2);
    pa = 0; pb = 0;
    @(negedge clk);
    chk("R8", "done drops after one cycle", int'(done), 0);
    en = 0;
  endtask

  task automatic t_field01;
    window(2'b01, 1'b0, L1, 1, 2, L1/2 - 2, L1/4 - 2, "R1");
    en = 0;
  endtask

  task automatic t_saturate;
    window(2'b10, 1'b0, L2, 1, 0, (1 << RW) - 1, 0, "R4");
    en = 0;
  endtask

  task automatic t_lowgain;
    window(2'b10, 1'b1, L2, 1, 2, (L2/2)/16 - 2, (L2/4)/16 - 2, "R5");
    en = 0;
  endtask

  task automatic t_manual;
    int early, late;
    en = 0; tsel = 2'b11; gain_lo = 0;
    @(negedge clk);
    en = 1; man_go = 1;
    run_cycles(100, 1, 2, early);
    chk("R9", "no strobe while held", early + int'(done), 0);
    man_go = 0; pa = 0; pb = 0;
    @(negedge clk);
    chk("R9", "done after release", int'(done), 1);
    chk("R9", "manual res_a", int'(ra), 48);
    chk("R9", "manual res_b", int'(rb), 23);
    run_cycles(50, 1, 1, late);
    chk("R9", "no strobe while released", late + int'(done), 0);
    chk("R9", "res_a held", int'(ra), 48);
  endtask

  task automatic t_abort;
    int e1, e2;
    en = 0; tsel = 2'b00; gain_lo = 0; man_go = 0;
    @(negedge clk);
    en = 1;
    run_cycles(100, 1, 1, e1);
    en = 0;
    run_cycles(200, 1, 1, e2);
    chk("R10", "no strobe around disable", e1 + e2 + int'(done), 0);
    chk("R10", "res_a unchanged", int'(ra), 48);
    chk("R10", "res_b unchanged", int'(rb), 23);
    window(2'b00, 1'b0, L0, 1, 1, L0/2 - 2, L0/2 - 2, "R10");
    en = 0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fullscale();
    t_period();
    t_field01();
    t_saturate();
    t_lowgain();
    t_manual();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule